// File: doc/BRIEF.md
# NAND Flash Controller Register Front-End

This block is the software-visible control face of a NAND flash controller. Eight 16-bit registers sit on a simple word-addressed bus. They hold the flash command byte, the flash address word, the buffer and chip-select selection, the operation trigger with its completion flag, the configuration word, the write-protect command and the two bounds of the unlocked block window. One write to the trigger register that sets a single operation bit launches that operation. The launch goes to a flash-side sequencer as a one-cycle start pulse. The sequencer answers with a done pulse, which sets a sticky completion flag and, unless masked, raises the interrupt.

The block also drives the flash chip enable, the active chip-select field, the buffer selection, the byte-order mode and the pages-per-block setting. A configuration bit starts a timed soft reset that returns all state to its reset values and then clears itself. A write-protect state machine, with a one-way lock-tight state, decides whether a given block may be written.

Register word addresses: 0 command, 1 flash address, 2 buffer/chip select, 3 operation trigger, 4 configuration, 5 write-protect, 6 unlock window start, 7 unlock window end.

Top module: `nand_ctl_regs`

## Requirements
- R1: After reset every register reads zero except write-protect, which reads 0x0002 (locked). ce_o, irq_o, seq_start_o and soft_rst_o are low, and blk_pages_o is 32.
- R2: A write to address 3 whose bits [5:0] have exactly one bit set launches an operation. The bits mean bit0 command, bit1 address, bit2 data input, bit3 data output, bit4 read ID and bit5 read status. seq_start_o pulses for the one cycle after the write, and seq_op_o shows the op bit while the operation is busy. Address 3 reads the busy op in bits [5:0].
- R3: A trigger write is ignored while an operation is busy. A trigger write with zero or several of bits [5:0] set is also ignored. In both cases there is no start pulse and seq_op_o does not change.
- R4: seq_done_i while busy ends the operation and sets bit 15 of address 3. The bit stays set until a write to address 3 with bit 15 at zero clears it, and a write with bit 15 at one leaves it set. seq_done_i while idle has no effect.
- R5: irq_o is the completion flag gated by configuration bit 4 (1 = masked).
- R6: When configuration bit 11 is set, irq_o is raised only if the completed operation was data input (bit2) or data output (bit3).
- R7: Configuration bit 7 drives ce_o and bit 5 drives big_endian_o. Address 2 bits [2:0] drive buf_sel_o and bits [6:5] drive cs_sel_o. The other bits of address 2 read as zero.
- R8: Configuration bits [10:9] set blk_pages_o: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. Configuration reads back bits 4, 5, 6, 7, 9, 10 and 11 only.
- R9: Writing configuration bit 6 holds soft_rst_o high for RST_CYCLES cycles (default 4), and bit 6 reads 1 during that time. Trigger writes are ignored during it. At its end all state, lock-tight included, returns to the R1 values.
- R10: Address 5 write bits are bit0 lock-tight, bit1 lock and bit2 unlock, with priority lock-tight, then lock, then unlock. It reads back the current state one-hot in the same bit positions.
- R11: Once lock-tight is set, writes to addresses 5, 6 and 7 are refused until reset.
- R12: wp_write_ok_o is high only when the state is unlocked and start <= wp_blk_i <= end, compared unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Bus write data |
| rdata_o | output | 16 | Bus read data for addr_i |
| seq_start_o | output | 1 | One-cycle operation start to the sequencer |
| seq_op_o | output | 6 | One-hot operation while busy |
| seq_cmd_o | output | 16 | Command register value |
| seq_addr_o | output | 16 | Flash address register value |
| seq_done_i | input | 1 | Operation finished pulse |
| irq_o | output | 1 | Completion interrupt |
| ce_o | output | 1 | Flash chip enable |
| cs_sel_o | output | 2 | Active chip select |
| buf_sel_o | output | 3 | Buffer RAM selection |
| big_endian_o | output | 1 | Byte-order mode for buffer transfers |
| blk_pages_o | output | 9 | Pages per erase block |
| soft_rst_o | output | 1 | Soft reset in progress |
| wp_blk_i | input | 16 | Block number to check against write protection |
| wp_write_ok_o | output | 1 | Block may be written |

## Verification
A stuck or lost busy state shows at once on the ports. Either the next legal trigger write gives no start pulse in the following cycle, or seq_op_o stays non-zero after done. A flag that is wrong shows in the same cycle on irq_o and on bit 15 of address 3, so the bench reads both after every done and every clear. A write-protect state that is wrong shows in the one-hot readback and on wp_write_ok_o for the blocks at the window edges. A soft-reset counter that is off by one shows as a soft_rst_o pulse that is one cycle too long or too short.

// File: rtl/nand_ctl_pkg.sv
package nand_ctl_pkg;
  localparam int DW   = 16;
  localparam int NOPS = 6;

  typedef enum logic [2:0] {
    RA_CMD  = 3'd0,
    RA_ADDR = 3'd1,
    RA_BUF  = 3'd2,
    RA_OP   = 3'd3,
    RA_CFG  = 3'd4,
    RA_WP   = 3'd5,
    RA_ULS  = 3'd6,
    RA_ULE  = 3'd7
  } reg_addr_e;

  localparam int OP_FLAG_BIT = 15;
  localparam int OP_DIN      = 2;
  localparam int OP_DOUT     = 3;

  localparam int CFG_IMASK = 4;
  localparam int CFG_BE    = 5;
  localparam int CFG_SRST  = 6;
  localparam int CFG_CE    = 7;
  localparam int CFG_PPB   = 9;
  localparam int CFG_FPI   = 11;

  localparam int WP_TIGHT_BIT = 0;
  localparam int WP_LOCK_BIT  = 1;
  localparam int WP_OPEN_BIT  = 2;

  typedef enum logic [1:0] {
    WP_LOCKED = 2'd0,
    WP_OPEN   = 2'd1,
    WP_TIGHT  = 2'd2
  } wp_state_e;
endpackage

// File: rtl/nand_op_launch.sv
module nand_op_launch #(
  parameter int NOPS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [NOPS-1:0] trig_i,
  input  logic            flag_wr_i,
  input  logic            done_i,
  output logic            start_o,
  output logic [NOPS-1:0] op_o,
  output logic            busy_o,
  output logic            flag_o,
  output logic [NOPS-1:0] last_op_o
);
  logic            busy_q, flag_q, start_q;
  logic [NOPS-1:0] op_q;
  logic            trig_ok, fin;

  assign trig_ok = wr_i && !busy_q && $onehot(trig_i);
  assign fin     = busy_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
      op_q    <= '0;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
      op_q    <= '0;
    end else begin
      start_q <= trig_ok;
      if (trig_ok) begin
        busy_q <= 1'b1;
        op_q   <= trig_i;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
      // completion wins over a same-cycle software clear
      if (fin)                    flag_q <= 1'b1;
      else if (wr_i && !flag_wr_i) flag_q <= 1'b0;
    end
  end

  assign start_o   = start_q;
  assign busy_o    = busy_q;
  assign flag_o    = flag_q;
  assign op_o      = busy_q ? op_q : '0;
  assign last_op_o = op_q;
endmodule

// File: rtl/nand_wp_guard.sv
module nand_wp_guard
  import nand_ctl_pkg::*;
#(
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cmd_wr_i,
  input  logic [2:0]    cmd_i,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [BW-1:0] blk_i,
  output wp_state_e     state_o,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          ok_o
);
  wp_state_e     st_q;
  logic [BW-1:0] lo_q, hi_q;
  logic          frozen;

  assign frozen = (st_q == WP_TIGHT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WP_LOCKED;
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      st_q <= WP_LOCKED;
      lo_q <= '0;
      hi_q <= '0;
    end else if (!frozen) begin
      if (cmd_wr_i) begin
        if (cmd_i[WP_TIGHT_BIT])     st_q <= WP_TIGHT;
        else if (cmd_i[WP_LOCK_BIT]) st_q <= WP_LOCKED;
        else if (cmd_i[WP_OPEN_BIT]) st_q <= WP_OPEN;
      end
      if (lo_wr_i) lo_q <= wdata_i;
      if (hi_wr_i) hi_q <= wdata_i;
    end
  end

  assign state_o = st_q;
  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign ok_o    = (st_q == WP_OPEN) && (blk_i >= lo_q) && (blk_i <= hi_q);
endmodule

// File: rtl/nand_soft_reset.sv
module nand_soft_reset #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o,
  output logic clr_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  assign clr_o = act_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (req_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (clr_o) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/nand_ctl_regs.sv
module nand_ctl_regs
  import nand_ctl_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int PPB_BASE   = 32,
  localparam int PGW       = $clog2(PPB_BASE * 8) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            seq_start_o,
  output logic [NOPS-1:0] seq_op_o,
  output logic [DW-1:0]   seq_cmd_o,
  output logic [DW-1:0]   seq_addr_o,
  input  logic            seq_done_i,
  output logic            irq_o,
  output logic            ce_o,
  output logic [1:0]      cs_sel_o,
  output logic [2:0]      buf_sel_o,
  output logic            big_endian_o,
  output logic [PGW-1:0]  blk_pages_o,
  output logic            soft_rst_o,
  input  logic [DW-1:0]   wp_blk_i,
  output logic            wp_write_ok_o
);
  logic            srst_act, srst_clr, we_eff;
  logic [DW-1:0]   cmd_q, faddr_q;
  logic [2:0]      buf_q;
  logic [1:0]      cs_q, ppb_q;
  logic            imask_q, be_q, ce_q, fpi_q;
  logic            op_busy, op_flag;
  logic [NOPS-1:0] last_op;
  wp_state_e       wp_st;
  logic [DW-1:0]   ul_lo, ul_hi;
  logic            wr_op, wr_cfg;

  assign we_eff = req_i && we_i && !srst_act;
  assign wr_op  = we_eff && (addr_i == RA_OP);
  assign wr_cfg = we_eff && (addr_i == RA_CFG);

  nand_soft_reset #(.CYC(RST_CYCLES)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (wr_cfg && wdata_i[CFG_SRST]),
    .active_o(srst_act),
    .clr_o   (srst_clr)
  );

  nand_op_launch #(.NOPS(NOPS)) u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst_clr),
    .wr_i     (wr_op),
    .trig_i   (wdata_i[NOPS-1:0]),
    .flag_wr_i(wdata_i[OP_FLAG_BIT]),
    .done_i   (seq_done_i),
    .start_o  (seq_start_o),
    .op_o     (seq_op_o),
    .busy_o   (op_busy),
    .flag_o   (op_flag),
    .last_op_o(last_op)
  );

  nand_wp_guard #(.BW(DW)) u_wp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_clr),
    .cmd_wr_i(we_eff && (addr_i == RA_WP)),
    .cmd_i   (wdata_i[2:0]),
    .lo_wr_i (we_eff && (addr_i == RA_ULS)),
    .hi_wr_i (we_eff && (addr_i == RA_ULE)),
    .wdata_i (wdata_i),
    .blk_i   (wp_blk_i),
    .state_o (wp_st),
    .lo_o    (ul_lo),
    .hi_o    (ul_hi),
    .ok_o    (wp_write_ok_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      faddr_q <= '0;
      buf_q   <= '0;
      cs_q    <= '0;
      imask_q <= 1'b0;
      be_q    <= 1'b0;
      ce_q    <= 1'b0;
      ppb_q   <= '0;
      fpi_q   <= 1'b0;
    end else if (srst_clr) begin
      cmd_q   <= '0;
      faddr_q <= '0;
      buf_q   <= '0;
      cs_q    <= '0;
      imask_q <= 1'b0;
      be_q    <= 1'b0;
      ce_q    <= 1'b0;
      ppb_q   <= '0;
      fpi_q   <= 1'b0;
    end else if (we_eff) begin
      unique case (addr_i)
        RA_CMD:  cmd_q   <= wdata_i;
        RA_ADDR: faddr_q <= wdata_i;
        RA_BUF: begin
          buf_q <= wdata_i[2:0];
          cs_q  <= wdata_i[6:5];
        end
        RA_CFG: begin
          imask_q <= wdata_i[CFG_IMASK];
          be_q    <= wdata_i[CFG_BE];
          ce_q    <= wdata_i[CFG_CE];
          ppb_q   <= wdata_i[CFG_PPB+1:CFG_PPB];
          fpi_q   <= wdata_i[CFG_FPI];
        end
        default: ;
      endcase
    end
  end

  logic page_done;
  assign page_done = last_op[OP_DIN] || last_op[OP_DOUT];
  assign irq_o     = op_flag && !imask_q && (!fpi_q || page_done);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_CMD:  rdata_o = cmd_q;
      RA_ADDR: rdata_o = faddr_q;
      RA_BUF: begin
        rdata_o[2:0] = buf_q;
        rdata_o[6:5] = cs_q;
      end
      RA_OP: begin
        rdata_o[OP_FLAG_BIT] = op_flag;
        rdata_o[NOPS-1:0]    = seq_op_o;
      end
      RA_CFG: begin
        rdata_o[CFG_IMASK]           = imask_q;
        rdata_o[CFG_BE]              = be_q;
        rdata_o[CFG_SRST]            = srst_act;
        rdata_o[CFG_CE]              = ce_q;
        rdata_o[CFG_PPB+1:CFG_PPB]   = ppb_q;
        rdata_o[CFG_FPI]             = fpi_q;
      end
      RA_WP: begin
        rdata_o[WP_TIGHT_BIT] = (wp_st == WP_TIGHT);
        rdata_o[WP_LOCK_BIT]  = (wp_st == WP_LOCKED);
        rdata_o[WP_OPEN_BIT]  = (wp_st == WP_OPEN);
      end
      RA_ULS:  rdata_o = ul_lo;
      RA_ULE:  rdata_o = ul_hi;
      default: rdata_o = '0;
    endcase
  end

  assign seq_cmd_o    = cmd_q;
  assign seq_addr_o   = faddr_q;
  assign ce_o         = ce_q;
  assign cs_sel_o     = cs_q;
  assign buf_sel_o    = buf_q;
  assign big_endian_o = be_q;
  assign blk_pages_o  = PGW'(PPB_BASE) << ppb_q;
  assign soft_rst_o   = srst_act;
endmodule

// File: rtl/nand_ctl_regs_chk.sv
module nand_ctl_regs_chk #(
  parameter int NOPS = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            seq_start_i,
  input logic [NOPS-1:0] seq_op_i,
  input logic            seq_done_i,
  input logic            irq_i,
  input logic            soft_rst_i,
  input logic            busy_i,
  input logic            flag_i,
  input logic            tight_i
);
  // R2
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_i |=> !seq_start_i);
  // R2
  start_onehot_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_i |-> $onehot(seq_op_i));
  // R3
  busy_op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !seq_done_i && !soft_rst_i) |=> $stable(seq_op_i));
  // R4
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && seq_done_i && !soft_rst_i) |=> (flag_i && !busy_i));
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i);
  // R9
  srst_end_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_i) |-> (!flag_i && !busy_i && !tight_i));
  // R11
  tight_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tight_i && !soft_rst_i) |=> tight_i);
endmodule

bind nand_ctl_regs nand_ctl_regs_chk #(.NOPS(nand_ctl_pkg::NOPS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .seq_start_i(seq_start_o),
  .seq_op_i   (seq_op_o),
  .seq_done_i (seq_done_i),
  .irq_i      (irq_o),
  .soft_rst_i (soft_rst_o),
  .busy_i     (op_busy),
  .flag_i     (op_flag),
  .tight_i    (wp_st == nand_ctl_pkg::WP_TIGHT)
);

// File: tb/tb_nand_ctl_regs.sv
`timescale 1ns/1ps
module tb_nand_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        start;
  logic [5:0]  op;
  logic [15:0] scmd, saddr;
  logic        done = 1'b0;
  logic        irq, ce, be, srst, wok;
  logic [1:0]  cs;
  logic [2:0]  bsel;
  logic [8:0]  pages;
  logic [15:0] blk = '0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  nand_ctl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .seq_start_o(start), .seq_op_o(op),
    .seq_cmd_o(scmd), .seq_addr_o(saddr), .seq_done_i(done), .irq_o(irq),
    .ce_o(ce), .cs_sel_o(cs), .buf_sel_o(bsel), .big_endian_o(be),
    .blk_pages_o(pages), .soft_rst_o(srst), .wp_blk_i(blk), .wp_write_ok_o(wok)
  );

  task automatic chk(input string req_s, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_s, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic fin();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  // {trigger data, launch expected, op expected}
  localparam logic [22:0] OPV [9] = '{
    {16'h0001, 1'b1, 6'h01}, {16'h0002, 1'b1, 6'h02}, {16'h0004, 1'b1, 6'h04},
    {16'h0008, 1'b1, 6'h08}, {16'h0010, 1'b1, 6'h10}, {16'h0020, 1'b1, 6'h20},
    {16'h0000, 1'b0, 6'h00}, {16'h0003, 1'b0, 6'h00}, {16'h0030, 1'b0, 6'h00}
  };
  // {config data, ce, big endian, pages}
  localparam logic [26:0] CFV [4] = '{
    {16'h0080, 1'b1, 1'b0, 9'd32},  {16'h02A0, 1'b1, 1'b1, 9'd64},
    {16'h0400, 1'b0, 1'b0, 9'd128}, {16'h0620, 1'b0, 1'b1, 9'd256}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk("R1 reg", r, (a == 5) ? 16'h0002 : 16'h0000);
    end
    chk("R1 ce", ce, 0); chk("R1 irq", irq, 0); chk("R1 start", start, 0);
    chk("R1 srst", srst, 0); chk("R1 pages", pages, 32);

    // R2 R3 R4 operation table
    for (int i = 0; i < 9; i++) begin
      wr(3'd3, OPV[i][22:7]);
      chk("R2 R3 start", start, OPV[i][6]);
      chk("R2 R3 op", op, OPV[i][5:0]);
      if (OPV[i][6]) begin
        rd(3'd3, r); chk("R2 op readback", r, OPV[i][5:0]);
        @(negedge clk);
        chk("R2 pulse end", start, 0);
        fin();
        rd(3'd3, r); chk("R4 flag set", r, 16'h8000);
        chk("R4 op idle", op, 0);
        wr(3'd3, 16'h0000);
      end
      rd(3'd3, r); chk("R4 flag clear", r, 16'h0000);
    end

    // R2 command/address presented
    wr(3'd0, 16'h0070); wr(3'd1, 16'h1234);
    chk("R2 cmd", scmd, 16'h0070); chk("R2 addr", saddr, 16'h1234);

    // R3 busy ignore, R4 sticky flag and idle done
    fin();
    rd(3'd3, r); chk("R4 idle done", r, 16'h0000);
    wr(3'd3, 16'h0002);
    wr(3'd3, 16'h0010);
    chk("R3 busy no start", start, 0); chk("R3 busy op", op, 6'h02);
    fin();
    wr(3'd3, 16'h8000);
    rd(3'd3, r); chk("R4 write one keeps", r, 16'h8000);
    chk("R3 no relaunch", start, 0);

    // R5 mask, R6 full-page qualifier
    chk("R5 irq", irq, 1);
    wr(3'd4, 16'h0010); chk("R5 masked", irq, 0);
    rd(3'd3, r); chk("R5 flag kept", r, 16'h8000);
    wr(3'd4, 16'h0000); chk("R5 unmasked", irq, 1);
    wr(3'd4, 16'h0800); chk("R6 non-page op", irq, 0);
    wr(3'd3, 16'h0008);
    fin();
    chk("R6 page op", irq, 1);
    wr(3'd3, 16'h0000); chk("R4 clear irq", irq, 0);

    // R7 R8 config table
    for (int i = 0; i < 4; i++) begin
      wr(3'd4, CFV[i][26:11]);
      chk("R7 ce", ce, CFV[i][10]); chk("R7 be", be, CFV[i][9]);
      chk("R8 pages", pages, CFV[i][8:0]);
      rd(3'd4, r); chk("R8 readback", r, CFV[i][26:11] & 16'h0EB0);
    end
    wr(3'd2, 16'h0065);
    chk("R7 buf", bsel, 5); chk("R7 cs", cs, 3);
    wr(3'd2, 16'hFF9A);
    rd(3'd2, r); chk("R7 buf readback", r, 16'h0002);

    // R10 R12 write protect
    wr(3'd5, 16'h0004);
    rd(3'd5, r); chk("R10 open", r, 16'h0004);
    wr(3'd6, 16'h0010); wr(3'd7, 16'h0020);
    blk = 16'h0010; #1 chk("R12 low edge", wok, 1);
    blk = 16'h0020; #1 chk("R12 high edge", wok, 1);
    blk = 16'h0021; #1 chk("R12 above", wok, 0);
    blk = 16'h000F; #1 chk("R12 below", wok, 0);
    blk = 16'h0018;
    wr(3'd5, 16'h0006);
    rd(3'd5, r); chk("R10 lock priority", r, 16'h0002);
    chk("R12 locked", wok, 0);
    wr(3'd5, 16'h0004); chk("R12 reopened", wok, 1);
    wr(3'd5, 16'h0005);
    rd(3'd5, r); chk("R10 tight priority", r, 16'h0001);
    // R11 refused changes
    wr(3'd5, 16'h0004);
    rd(3'd5, r); chk("R11 cmd refused", r, 16'h0001);
    wr(3'd6, 16'h0000);
    rd(3'd6, r); chk("R11 range refused", r, 16'h0010);
    chk("R11 not ok", wok, 0);

    // R9 soft reset
    wr(3'd4, 16'h0080);
    wr(3'd3, 16'h0001);
    fin();
    wr(3'd4, 16'h0040);
    chk("R9 active", srst, 1);
    rd(3'd4, r); chk("R9 bit reads one", r[6], 1);
    wr(3'd3, 16'h0002);
    chk("R9 trigger ignored", start, 0);
    n = 2;
    while (srst && n < 50) begin
      @(negedge clk);
      if (srst) n++;
    end
    chk("R9 length", n, 4);
    rd(3'd4, r); chk("R9 cfg cleared", r, 16'h0000);
    rd(3'd3, r); chk("R9 flag cleared", r, 16'h0000);
    rd(3'd5, r); chk("R9 tight cleared", r, 16'h0002);
    chk("R9 ce", ce, 0); chk("R9 irq", irq, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule